// File: doc/BRIEF.md
# Copper Port Crossover and Link-Ability Sequencer

This block brings up one twisted-pair port without software help. On a start pulse it selects straight (MDI) wiring, waits a fixed number of millisecond ticks, and reads the attached PHY's basic status register through a read-request port. The serial management framing sits outside this block. If the link is down, it flips the crossover select and tries again, alternating the wiring on every failed poll until a poll limit is reached.

Once the link is up, the block reads the PHY again to confirm that negotiation or parallel detection has finished. It then reads the resolved speed and duplex. If the PHY reports that it can negotiate, the block walks the pause capability chain: the expansion register, then the local advertisement, then the partner advertisement. Each read takes place only when the one before it allows it. The result is a small port status word with link, speed, duplex and pause bits. A done flag marks the end of the sequence, and a fail flag marks the case where no link was found.

Top module: `mdix_link_seq`

## Requirements
- R1: While idle, a `start` pulse clears `link_status`, `done` and `fail`, drives `xover_sel` low (MDI) and begins the first delay. After reset, all outputs are low.
- R2: Each basic-status poll (register 1) is issued only after exactly `DELAY_MS` cycles in which `tick_ms` was sampled high since the delay began.
- R3: Every read drives `mdio_phy` = `PHY_ADDR`. `mdio_req` stays high with `mdio_reg` unchanged until a cycle with `mdio_ack` high, and the read data is taken from `mdio_rdata` in that cycle. Only one read is outstanding at a time.
- R4: Bit 2 of register 1 means link up. A poll that returns it clear inverts `xover_sel`, so that poll k (counting from 0) runs with `xover_sel` = k mod 2.
- R5: After `MAX_POLLS` polls that all return link down, `done` and `fail` rise together, `link_status` stays 0, and no further reads are issued.
- R6: After link up, register 1 is read once more. If its bit 5 is clear, `done` rises with `fail` low and `link_status` left at 0.
- R7: If bit 5 is set, register 31 is read and its bits 4:2 are decoded: 1 = 10 Mb/s half, 5 = 10 Mb/s full, 2 = 100 Mb/s half, 6 = 100 Mb/s full. `link_status[0]` is set for 100 Mb/s and `link_status[1]` for full duplex. Any other code leaves both bits clear.
- R8: The pause chain runs only when bit 3 of the second register 1 read is set. It reads register 6 and needs bit 0 set, then reads register 4 and needs bit 10 set, then reads register 5. `link_status[3]` is set only if bit 10 of register 5 is also set. Each read is skipped when the previous condition fails.
- R9: Whenever the status word is written, `link_status[2]` (link) is set. `done` then rises with `fail` low and `mdio_req` stays low.
- R10: A `start` pulse that arrives while a sequence is running has no effect on the read order, the wiring select or the final status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a bring-up sequence (taken only while idle) |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| xover_sel | output | 1 | Wiring select, 0 = straight, 1 = crossed |
| mdio_req | output | 1 | Read request to the management port |
| mdio_phy | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Register address of the request |
| mdio_ack | input | 1 | Read complete, data valid this cycle |
| mdio_rdata | input | 16 | Read data |
| link_status | output | 4 | {pause, link, full duplex, 100 Mb/s} |
| done | output | 1 | Sequence finished (held until next start) |
| fail | output | 1 | No link found within the poll limit |

## Verification
The assertions check on every cycle that a pending read holds its address and the wiring select until it is acknowledged. They also check that a failure leaves the status word empty and comes with done, that done is quiet on the request port, that any written status word carries the link bit, and that a start taken at completion clears done. The order of reads through the conditional pause chain, the alternation of wiring over polls, the exact tick count before each poll, the mode decode, and the rejection of a start pulse mid-sequence depend on the PHY's answers. Only the bench scenarios, with their scripted responder and expected read queue, can show these.

// File: rtl/mdix_pkg.sv
// Shared types and constants for the crossover/link sequencer.
// Assumes 16-bit PHY management registers and 5-bit addresses.
package mdix_pkg;
    localparam int MD_DATA_W = 16;
    localparam int MD_ADDR_W = 5;
    localparam int STS_W     = 4;

    // Sequencer states; the read states each own one register address.
    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_POLL,
        SQ_CONFIRM,
        SQ_RESOLVE,
        SQ_ANEXP,
        SQ_ADV,
        SQ_PARTNER,
        SQ_COMMIT
    } seq_state_t;

    // PHY register addresses.
    localparam logic [MD_ADDR_W-1:0] PREG_BSR   = 5'd1;
    localparam logic [MD_ADDR_W-1:0] PREG_ADV   = 5'd4;
    localparam logic [MD_ADDR_W-1:0] PREG_LPA   = 5'd5;
    localparam logic [MD_ADDR_W-1:0] PREG_ANEXP = 5'd6;
    localparam logic [MD_ADDR_W-1:0] PREG_MODE  = 5'd31;

    // Bit positions inside the PHY registers.
    localparam int BSR_LINK   = 2;
    localparam int BSR_ANABLE = 3;
    localparam int BSR_ANDONE = 5;
    localparam int ANEXP_LPAN = 0;
    localparam int PAUSE_BIT  = 10;

    // Bit positions inside the port status word.
    localparam int STS_FAST  = 0;
    localparam int STS_FULL  = 1;
    localparam int STS_LINK  = 2;
    localparam int STS_PAUSE = 3;
endpackage

// File: rtl/mdix_ms_timer.sv
// Counts millisecond ticks while enabled and flags when DELAY_MS ticks
// have been seen. Assumes tick is a single-cycle pulse. The count clears
// whenever run is low, so each delay starts from zero.
module mdix_ms_timer #(
    parameter int DELAY_MS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int TW = (DELAY_MS > 0) ? $clog2(DELAY_MS + 1) : 1;

    logic [TW-1:0] cnt_q;

    assign expired = (cnt_q == TW'(DELAY_MS));

    // Advance on each tick while running, hold at the limit, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdix_poll_counter.sv
// Counts failed link polls. last is high when the poll now being answered
// is the final one allowed. Assumes MAX_POLLS >= 1.
module mdix_poll_counter #(
    parameter int MAX_POLLS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

    logic [PW-1:0] cnt_q;

    assign last = (cnt_q == PW'(MAX_POLLS - 1));

    // Clear at the start of a sequence, step on every failed poll.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdix_mode_decode.sv
// Maps the PHY's resolved-mode code to speed and duplex flags.
// Purely combinational; codes other than the four known ones give 10/half.
module mdix_mode_decode (
    input  logic [2:0] code,
    output logic       fast,
    output logic       full
);
    // Decode the resolved mode.
    always_comb begin
        fast = 1'b0;
        full = 1'b0;
        case (code)
            3'd1: begin fast = 1'b0; full = 1'b0; end
            3'd5: begin fast = 1'b0; full = 1'b1; end
            3'd2: begin fast = 1'b1; full = 1'b0; end
            3'd6: begin fast = 1'b1; full = 1'b1; end
            default: begin fast = 1'b0; full = 1'b0; end
        endcase
    end
endmodule

// File: rtl/mdix_link_seq.sv
// Brings up one copper port: alternates straight/crossed wiring on each
// failed link poll, then reads the PHY's resolved mode and pause ability
// into a status word. Assumes a management read port that holds off with
// mdio_ack low and returns data in the single cycle that mdio_ack is high.
module mdix_link_seq
    import mdix_pkg::*;
#(
    parameter int              MAX_POLLS = 100,
    parameter int              DELAY_MS  = 2000,
    parameter logic [4:0]      PHY_ADDR  = 5'd6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        tick_ms,
    output logic        xover_sel,
    output logic        mdio_req,
    output logic [4:0]  mdio_phy,
    output logic [4:0]  mdio_reg,
    input  logic        mdio_ack,
    input  logic [15:0] mdio_rdata,
    output logic [3:0]  link_status,
    output logic        done,
    output logic        fail
);
    seq_state_t state_q;
    logic       xover_q;
    logic       done_q;
    logic       fail_q;
    logic [STS_W-1:0] status_q;
    logic       ability_q;
    logic       fast_q;
    logic       full_q;
    logic       pause_q;

    logic       timer_run;
    logic       timer_expired;
    logic       poll_clr;
    logic       poll_inc;
    logic       poll_last;
    logic       dec_fast;
    logic       dec_full;
    logic       link_seen;
    logic       unused_rdata_bits;

    assign link_seen = mdio_rdata[BSR_LINK];
    assign unused_rdata_bits = ^{mdio_rdata[15:11], mdio_rdata[9:6], mdio_rdata[1]};

    assign timer_run = (state_q == SQ_WAIT);
    assign poll_clr  = (state_q == SQ_IDLE) && start;
    assign poll_inc  = (state_q == SQ_POLL) && mdio_ack && !link_seen;

    mdix_ms_timer #(.DELAY_MS(DELAY_MS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .tick    (tick_ms),
        .expired (timer_expired)
    );

    mdix_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_polls (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .inc   (poll_inc),
        .last  (poll_last)
    );

    mdix_mode_decode u_decode (
        .code (mdio_rdata[4:2]),
        .fast (dec_fast),
        .full (dec_full)
    );

    // Request port: one register address per read state.
    always_comb begin
        mdio_req = 1'b1;
        mdio_reg = PREG_BSR;
        case (state_q)
            SQ_POLL:    mdio_reg = PREG_BSR;
            SQ_CONFIRM: mdio_reg = PREG_BSR;
            SQ_RESOLVE: mdio_reg = PREG_MODE;
            SQ_ANEXP:   mdio_reg = PREG_ANEXP;
            SQ_ADV:     mdio_reg = PREG_ADV;
            SQ_PARTNER: mdio_reg = PREG_LPA;
            default: begin
                mdio_req = 1'b0;
                mdio_reg = PREG_BSR;
            end
        endcase
    end

    assign mdio_phy    = PHY_ADDR;
    assign xover_sel   = xover_q;
    assign done        = done_q;
    assign fail        = fail_q;
    assign link_status = status_q;

    // Main sequence: delay, poll, confirm, resolve mode, pause chain, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            xover_q   <= 1'b0;
            done_q    <= 1'b0;
            fail_q    <= 1'b0;
            status_q  <= '0;
            ability_q <= 1'b0;
            fast_q    <= 1'b0;
            full_q    <= 1'b0;
            pause_q   <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        state_q   <= SQ_WAIT;
                        xover_q   <= 1'b0;
                        done_q    <= 1'b0;
                        fail_q    <= 1'b0;
                        status_q  <= '0;
                        ability_q <= 1'b0;
                        fast_q    <= 1'b0;
                        full_q    <= 1'b0;
                        pause_q   <= 1'b0;
                    end
                end
                SQ_WAIT: begin
                    if (timer_expired) begin
                        state_q <= SQ_POLL;
                    end
                end
                SQ_POLL: begin
                    if (mdio_ack) begin
                        if (link_seen) begin
                            state_q <= SQ_CONFIRM;
                        end else begin
                            xover_q <= ~xover_q;
                            if (poll_last) begin
                                state_q <= SQ_IDLE;
                                done_q  <= 1'b1;
                                fail_q  <= 1'b1;
                            end else begin
                                state_q <= SQ_WAIT;
                            end
                        end
                    end
                end
                SQ_CONFIRM: begin
                    if (mdio_ack) begin
                        ability_q <= mdio_rdata[BSR_ANABLE];
                        if (mdio_rdata[BSR_ANDONE]) begin
                            state_q <= SQ_RESOLVE;
                        end else begin
                            state_q <= SQ_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                SQ_RESOLVE: begin
                    if (mdio_ack) begin
                        fast_q  <= dec_fast;
                        full_q  <= dec_full;
                        state_q <= ability_q ? SQ_ANEXP : SQ_COMMIT;
                    end
                end
                SQ_ANEXP: begin
                    if (mdio_ack) begin
                        state_q <= mdio_rdata[ANEXP_LPAN] ? SQ_ADV : SQ_COMMIT;
                    end
                end
                SQ_ADV: begin
                    if (mdio_ack) begin
                        state_q <= mdio_rdata[PAUSE_BIT] ? SQ_PARTNER : SQ_COMMIT;
                    end
                end
                SQ_PARTNER: begin
                    if (mdio_ack) begin
                        pause_q <= mdio_rdata[PAUSE_BIT];
                        state_q <= SQ_COMMIT;
                    end
                end
                SQ_COMMIT: begin
                    status_q[STS_FAST]  <= fast_q;
                    status_q[STS_FULL]  <= full_q;
                    status_q[STS_LINK]  <= 1'b1;
                    status_q[STS_PAUSE] <= pause_q;
                    done_q  <= 1'b1;
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdix_link_seq_chk.sv
// Checker for the sequencer's port-level rules, bound to every instance.
module mdix_link_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       xover_sel,
    input logic       mdio_req,
    input logic [4:0] mdio_reg,
    input logic       mdio_ack,
    input logic [3:0] link_status,
    input logic       done,
    input logic       fail
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req && !mdio_ack |=> mdio_req && $stable(mdio_reg)); // R3

    AST_XOVER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req && !mdio_ack |=> $stable(xover_sel)); // R4

    AST_FAIL_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> link_status == 4'd0); // R5

    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done); // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mdio_req); // R9

    AST_LINK_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        link_status != 4'd0 |-> link_status[2]); // R9

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done && start |=> !done && !fail); // R1
endmodule

bind mdix_link_seq mdix_link_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .xover_sel   (xover_sel),
    .mdio_req    (mdio_req),
    .mdio_reg    (mdio_reg),
    .mdio_ack    (mdio_ack),
    .link_status (link_status),
    .done        (done),
    .fail        (fail)
);

// File: tb/tb_mdix_link_seq.sv
module tb_mdix_link_seq;
    localparam int NPOLL = 6;
    localparam int NDLY  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tick_ms = 1'b0;
    logic        xover_sel;
    logic        mdio_req;
    logic [4:0]  mdio_phy;
    logic [4:0]  mdio_reg;
    logic        mdio_ack = 1'b0;
    logic [15:0] mdio_rdata = 16'h0;
    logic [3:0]  link_status;
    logic        done;
    logic        fail;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Scenario knobs read by the PHY responder.
    int link_at = 0;
    bit s_b5 = 1, s_b3 = 1, s_r6 = 1, s_r4 = 1, s_r5 = 1;
    int s_mode = 6;
    int bsr_reads = 0;

    // Expected reads: register and required wiring (-1 = not a poll).
    int exp_reg[$];
    int exp_x[$];

    // Start pulse requests from the scenario task and busy-start arming.
    int go_cnt = 0, go_seen = 0;
    bit arm_busy = 0, busy_fired = 0;

    mdix_link_seq #(.MAX_POLLS(NPOLL), .DELAY_MS(NDLY), .PHY_ADDR(5'd6)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tick_ms(tick_ms),
        .xover_sel(xover_sel), .mdio_req(mdio_req), .mdio_phy(mdio_phy),
        .mdio_reg(mdio_reg), .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata),
        .link_status(link_status), .done(done), .fail(fail)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Tick generator: one pulse every third cycle.
    int tphase = 0;
    always @(negedge clk) begin
        tphase <= (tphase == 2) ? 0 : tphase + 1;
        tick_ms <= (tphase == 2);
        cycles++;
    end

    // Start driver: scenario pulses, plus one pulse while busy when armed.
    always @(negedge clk) begin
        start <= 1'b0;
        if (go_cnt != go_seen) begin
            start <= 1'b1;
            go_seen <= go_cnt;
        end else if (arm_busy && !busy_fired && mdio_req && mdio_reg == 5'd31) begin
            start <= 1'b1;
            busy_fired <= 1'b1;
        end
        if (!arm_busy) busy_fired <= 1'b0;
    end

    function automatic logic [15:0] phy_answer(input int r, input int bidx);
        logic [15:0] d;
        d = 16'h0;
        case (r)
            1: d = 16'h7801 | (16'(s_b5) << 5) | (16'(s_b3) << 3)
                   | ((bidx >= link_at) ? 16'h0004 : 16'h0000);
            31: d = 16'h8003 | (16'(s_mode) << 2);
            6: d = 16'h0C02 | 16'(s_r6);
            4: d = 16'h0201 | (16'(s_r4) << 10);
            5: d = 16'h0201 | (16'(s_r5) << 10);
            default: d = 16'h0;
        endcase
        return d;
    endfunction

    // PHY responder: answers each request after a short, varying latency.
    bit pend = 0;
    int lat = 0;
    int lreg = 0;
    int nreq = 0;
    always @(negedge clk) begin
        if (mdio_ack) begin
            mdio_ack <= 1'b0;
        end else if (pend) begin
            if (lat == 0) begin
                mdio_ack <= 1'b1;
                mdio_rdata <= phy_answer(lreg, bsr_reads);
                if (lreg == 1) bsr_reads <= bsr_reads + 1;
                pend <= 1'b0;
            end else begin
                lat <= lat - 1;
            end
        end else if (mdio_req) begin
            pend <= 1'b1;
            lreg <= int'(mdio_reg);
            lat <= nreq % 3;
            nreq <= nreq + 1;
        end
    end

    // Reference monitor: compares every new request with the expected queue
    // and counts the ticks that preceded each poll.
    bit prev_req = 0;
    int tcount = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (start || mdio_ack) tcount = 0;
            else if (tick_ms && !mdio_req) tcount++;
            if (mdio_req && (mdio_ack || !prev_req)) begin
                check(mdio_phy == 5'd6, "R3 phy address", mdio_phy, 6);
                if (exp_reg.size() == 0) begin
                    check(0, "R3 unexpected read", mdio_reg, -1);
                end else begin
                    int er, ex;
                    er = exp_reg.pop_front();
                    ex = exp_x.pop_front();
                    check(int'(mdio_reg) == er, "R8 read order", mdio_reg, er);
                    if (ex >= 0) begin
                        check(int'(xover_sel) == ex, "R4 wiring on poll", xover_sel, ex);
                        check(tcount == NDLY, "R2 ticks before poll", tcount, NDLY);
                    end
                end
            end
            prev_req = mdio_req;
        end
    end

    // Global watchdog.
    initial begin
        wait (cycles >= 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic run_case(input string name, input int la, input bit b5, input bit b3,
                            input int mode, input bit r6, input bit r4, input bit r5,
                            input bit busy);
        int exp_st, fast, full, pause, waited;
        bit exp_fail;
        link_at = la; s_b5 = b5; s_b3 = b3; s_mode = mode;
        s_r6 = r6; s_r4 = r4; s_r5 = r5;
        bsr_reads = 0;
        exp_reg.delete(); exp_x.delete();
        for (int p = 0; p < NPOLL && p <= la; p++) begin
            exp_reg.push_back(1); exp_x.push_back(p % 2);
        end
        exp_fail = (la >= NPOLL);
        exp_st = 0;
        if (!exp_fail) begin
            exp_reg.push_back(1); exp_x.push_back(-1);
            if (b5) begin
                exp_reg.push_back(31); exp_x.push_back(-1);
                if (b3) begin
                    exp_reg.push_back(6); exp_x.push_back(-1);
                    if (r6) begin
                        exp_reg.push_back(4); exp_x.push_back(-1);
                        if (r4) begin exp_reg.push_back(5); exp_x.push_back(-1); end
                    end
                end
                fast = (mode == 2 || mode == 6);
                full = (mode == 5 || mode == 6);
                pause = b3 && r6 && r4 && r5;
                exp_st = (pause << 3) | 4 | (full << 1) | fast;
            end
        end
        arm_busy = busy;
        go_cnt++;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done cleared by start", done, 0);
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, {"R9 done reached ", name}, done, 1);
        check(fail == exp_fail, {"R5 fail flag ", name}, fail, exp_fail);
        check(int'(link_status) == exp_st, {"R7 status ", name}, link_status, exp_st);
        check(exp_reg.size() == 0, {"R8 all reads issued ", name}, exp_reg.size(), 0);
        if (exp_fail)
            check(xover_sel == NPOLL[0], "R4 wiring after fail", xover_sel, NPOLL % 2);
        repeat (8) @(negedge clk);
        check(mdio_req == 1'b0, {"R5 quiet after done ", name}, mdio_req, 0);
        check(int'(link_status) == exp_st, {"R10 status kept ", name}, link_status, exp_st);
        arm_busy = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 0 && fail == 0, "R1 reset flags", {done, fail}, 0);
        check(link_status == 0, "R1 reset status", link_status, 0);
        check(xover_sel == 0 && mdio_req == 0, "R1 reset select/req", {xover_sel, mdio_req}, 0);
        run_case("full chain 100F", 0, 1, 1, 6, 1, 1, 1, 0);
        run_case("link on poll 3 10H", 3, 1, 0, 1, 1, 1, 1, 0);
        run_case("R8 stop at reg6 10F", 1, 1, 1, 5, 0, 1, 1, 0);
        run_case("R8 stop at reg4 100H", 2, 1, 1, 2, 1, 0, 1, 0);
        run_case("R8 partner no pause", 0, 1, 1, 6, 1, 1, 0, 0);
        run_case("R6 not complete", 1, 0, 1, 6, 1, 1, 1, 0);
        run_case("R7 unknown code", 0, 1, 0, 3, 1, 1, 1, 0);
        run_case("R5 never link", NPOLL + 5, 1, 1, 6, 1, 1, 1, 0);
        run_case("R10 busy start", 2, 1, 1, 6, 1, 1, 1, 1);
        run_case("last poll links", NPOLL - 1, 1, 1, 5, 1, 1, 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule